// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns external interrupt activity into a single pending request for the CPU. It watches two sources. One is a dedicated interrupt pin that is active low and already synchronized to the clock. The other is a group of four port pins that are active high. The port pins are merged after their polarity is normalised, so the group acts as a second source. When either source triggers, a pending flag is set and drives the interrupt request line. The flag stays set until the CPU acknowledges it with a one-cycle pulse.

A configuration bit chooses how the sources trigger. In edge-only mode, a source must return to its idle level before it can raise a new request. In edge-or-level mode, a source that is held active keeps requesting, which suits several open-drain sources sharing one wire. The port group is routed into the request path only when two bits are both set: a group configuration bit and an enable bit at register level.

Top module: `ext_irq_latch`

## Requirements
- R1: Reset clears the pending flag. After reset, while every source is at its idle level (interrupt pin high, all port pins low), the flag stays clear.
- R2: In edge-only mode (`trig_mode` = 0), a high-to-low change on `irq_pin_n` between two clock samples sets `pending` at the next clock edge.
- R3: In edge-only mode, a source held at its active level cannot set `pending` again after an acknowledge. A new request is latched only after the source returns to idle and then becomes active again.
- R4: In edge-or-level mode (`trig_mode` = 1), an active level on any enabled source sets `pending`. If that level is still present when an acknowledge arrives, `pending` reads 0 for exactly one cycle and then is set again.
- R5: An `ack` pulse clears `pending` at the next clock edge, provided no new edge arrives in the same cycle.
- R6: An edge that arrives in the same cycle as `ack` wins, and `pending` stays 1.
- R7: When the port group is enabled, the OR of the four port pins acts as one active-high source. It triggers on a rising edge in edge-only mode, and on a rising edge or a high level in edge-or-level mode.
- R8: When `port_grp_en` or `port_irq_en` is 0, the port pins have no effect on `pending`, in either mode.
- R9: In edge-only mode, while at least one port pin is high, another port pin rising does not raise a new request.
- R10: `irq_req` equals `pending` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pin_n | input | 1 | Synchronized interrupt pin, active low |
| port_pins | input | 4 | Port pins usable as interrupt sources, active high |
| trig_mode | input | 1 | 0 = edge only, 1 = edge or level |
| port_grp_en | input | 1 | Configuration bit that routes the port group into the request path |
| port_irq_en | input | 1 | Register-level enable for the port group |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| pending | output | 1 | Pending request flag |
| irq_req | output | 1 | Interrupt request line to the CPU |

## Verification
Two situations are hard to reach from the ports. The first is an edge arriving in the same clock as an acknowledge: the stimulus first parks the flag at 1 with the pin released, then pulls the pin low in the very cycle that carries `ack`. The second is the single idle cycle that follows an acknowledge in level mode, which needs a source held active across the `ack` cycle and the cycle after it. For the port group, one pin is kept high while a second pin rises, which shows that the merged source sees no new edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int unsigned NPORT_DEF = 4;
  localparam int unsigned NSRC      = 2;
  localparam int unsigned SRC_PIN   = 0;
  localparam int unsigned SRC_PORT  = 1;

  typedef enum logic {
    TRIG_EDGE       = 1'b0,
    TRIG_EDGE_LEVEL = 1'b1
  } trig_mode_e;

  // Idle-to-active transition of a normalised (active-high) source.
  function automatic logic f_rise(input logic prev_act, input logic cur_act);
    return cur_act && !prev_act;
  endfunction

  // Next value of the pending flag: an edge beats ack; a level does not.
  function automatic logic f_next_pending(input logic pend, input logic edge_hit,
                                          input logic level_hit, input logic ack_in);
    return edge_hit || ((level_hit || pend) && !ack_in);
  endfunction

endpackage

// File: rtl/irq_src_norm.sv
module irq_src_norm
  import ext_irq_pkg::*;
#(
  parameter int unsigned NPORT = NPORT_DEF
) (
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pins,
  input  logic             port_grp_en,
  input  logic             port_irq_en,
  output logic             port_gate,
  output logic [NSRC-1:0]  src_act
);

  logic port_any;

  assign port_gate = port_grp_en && port_irq_en;
  assign port_any  = |port_pins;

  always_comb begin
    src_act           = '0;
    src_act[SRC_PIN]  = !irq_pin_n;
    src_act[SRC_PORT] = port_gate && port_any;
  end

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import ext_irq_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] act,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_act;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) prev_act[g] <= 1'b0;
      else        prev_act[g] <= act[g];
    end
    assign rise[g] = f_rise(prev_act[g], act[g]);
  end

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import ext_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_evt,
  input  logic level_evt,
  input  logic ack,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= f_next_pending(pending, edge_evt, level_evt, ack);
  end

endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int unsigned NPORT = NPORT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pins,
  input  logic             trig_mode,
  input  logic             port_grp_en,
  input  logic             port_irq_en,
  input  logic             ack,
  output logic             pending,
  output logic             irq_req
);

  logic [NSRC-1:0] src_act;
  logic [NSRC-1:0] src_rise;
  logic            port_gate;
  logic            edge_evt;
  logic            level_evt;
  trig_mode_e      mode;

  assign mode = trig_mode_e'(trig_mode);

  irq_src_norm #(.NPORT(NPORT)) u_norm (
    .irq_pin_n   (irq_pin_n),
    .port_pins   (port_pins),
    .port_grp_en (port_grp_en),
    .port_irq_en (port_irq_en),
    .port_gate   (port_gate),
    .src_act     (src_act)
  );

  irq_edge_det #(.N(NSRC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (src_act),
    .rise  (src_rise)
  );

  assign edge_evt  = |src_rise;
  assign level_evt = (mode == TRIG_EDGE_LEVEL) && (|src_act);

  irq_pend_latch u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_evt  (edge_evt),
    .level_evt (level_evt),
    .ack       (ack),
    .pending   (pending)
  );

  assign irq_req = pending;

endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_pin_n,
  input logic trig_mode,
  input logic port_gate,
  input logic ack,
  input logic edge_evt,
  input logic level_evt,
  input logic pending,
  input logic irq_req
);

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> !pending);

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> pending);

  assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_mode && !edge_evt && !pending) |=> !pending);

  assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (level_evt && !ack) |=> pending);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_evt) |=> !pending);

  assert_edge_beats_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && ack) |=> pending);

  assert_port_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_gate && irq_pin_n && !pending) |=> !pending);

  assert_req_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == pending);

endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_pin_n (irq_pin_n),
  .trig_mode (trig_mode),
  .port_gate (port_gate),
  .ack       (ack),
  .edge_evt  (edge_evt),
  .level_evt (level_evt),
  .pending   (pending),
  .irq_req   (irq_req)
);

// File: tb/ext_irq_latch_tb.sv
module ext_irq_latch_tb;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b1;
  logic [3:0] port_pins = 4'b0000;
  logic       trig_mode = 1'b0;
  logic       port_grp_en = 1'b1;
  logic       port_irq_en = 1'b1;
  logic       ack = 1'b0;
  logic       pending;
  logic       irq_req;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  ext_irq_latch u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_n   (irq_pin_n),
    .port_pins   (port_pins),
    .trig_mode   (trig_mode),
    .port_grp_en (port_grp_en),
    .port_irq_en (port_irq_en),
    .ack         (ack),
    .pending     (pending),
    .irq_req     (irq_req)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected flag.
  task automatic step(input logic pin_n, input logic [3:0] pins, input logic mode,
                      input logic grp, input logic pen, input logic ak,
                      input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    irq_pin_n   = pin_n;
    port_pins   = pins;
    trig_mode   = mode;
    port_grp_en = grp;
    port_irq_en = pen;
    ack         = ak;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(pending, it.exp, it.tag);
        check(irq_req, pending, "R10");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(pending, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // edge-only, main pin
    step(1, 4'b0000, 0, 1, 1, 0, 0, "R1");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R2");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R2");
    step(0, 4'b0000, 0, 1, 1, 1, 0, "R5");
    step(0, 4'b0000, 0, 1, 1, 0, 0, "R3");
    step(1, 4'b0000, 0, 1, 1, 0, 0, "R3");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R3");
    step(1, 4'b0000, 0, 1, 1, 1, 0, "R5");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R2");
    step(1, 4'b0000, 0, 1, 1, 0, 1, "R3");
    step(0, 4'b0000, 0, 1, 1, 1, 1, "R6");
    step(1, 4'b0000, 0, 1, 1, 1, 0, "R5");
    // edge-or-level, main pin
    step(1, 4'b0000, 1, 1, 1, 0, 0, "R4");
    step(0, 4'b0000, 1, 1, 1, 0, 1, "R4");
    step(0, 4'b0000, 1, 1, 1, 1, 0, "R4");
    step(0, 4'b0000, 1, 1, 1, 0, 1, "R4");
    step(1, 4'b0000, 1, 1, 1, 1, 0, "R5");
    step(1, 4'b0000, 1, 1, 1, 0, 0, "R4");
    // port group, edge-only
    step(1, 4'b0001, 0, 1, 1, 0, 1, "R7");
    step(1, 4'b0001, 0, 1, 1, 1, 0, "R5");
    step(1, 4'b0011, 0, 1, 1, 0, 0, "R9");
    step(1, 4'b0010, 0, 1, 1, 0, 0, "R9");
    step(1, 4'b0000, 0, 1, 1, 0, 0, "R3");
    step(1, 4'b1000, 0, 1, 1, 0, 1, "R7");
    step(1, 4'b0000, 0, 1, 1, 1, 0, "R5");
    // port gating
    step(1, 4'b0100, 0, 1, 0, 0, 0, "R8");
    step(1, 4'b0000, 0, 1, 0, 0, 0, "R8");
    step(1, 4'b0100, 0, 0, 1, 0, 0, "R8");
    step(1, 4'b1111, 1, 0, 1, 0, 0, "R8");
    step(1, 4'b0000, 1, 1, 1, 0, 0, "R8");
    // port group, edge-or-level
    step(1, 4'b0100, 1, 1, 1, 0, 1, "R7");
    step(1, 4'b0100, 1, 1, 1, 1, 0, "R4");
    step(1, 4'b0100, 1, 1, 1, 0, 1, "R7");
    step(1, 4'b0000, 1, 1, 1, 1, 0, "R5");
    step(1, 4'b0000, 1, 1, 1, 0, 0, "R1");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule